// File: doc/BRIEF.md
# Fence Slot LRU Allocator

This block keeps track of a small pool of detiling fence slots that many memory objects compete for. A slot is either free or owned by one object ID, and it carries a pin count that protects it from being taken away. On a request to obtain a slot for an object, the block does one of three things. It returns the slot the object already holds. Failing that, it grants the lowest free slot at or above a configured first index. Failing that, it steals the least-recently-used unpinned slot and reports the previous owner as evicted, so that the surrounding logic can drain that owner's accesses and reprogram the slot.

Release, pin and unpin commands work on the slot the given object owns. One command is accepted per cycle. The result appears on the response outputs on the following cycle. Recency is held as one age counter per slot, where age 0 marks the most recently used owned slot. When no slot can be granted, the response separates a transient shortage, signalled by the release-pending input, from a true deadlock.

Top module: `fence_slot_alloc`

## Requirements
- R1: A get (op 0) for a tiled object that owns no slot grants the lowest-numbered free slot with index at least FIRST_SLOT. The response is status OK (0), rsp_evict low, and rsp_slot set to that index.
- R2: When no slot is free, a tiled get takes the owned slot with pin count zero that was used least recently. The response is status OK, rsp_evict high, and rsp_evict_id set to the previous owner. Pinned slots are never taken.
- R3: When every owned slot is pinned and none is free, a tiled get grants nothing. The status is RETRY (1) if release_pending is high and DEADLOCK (2) if it is low.
- R4: A get with cmd_dirty low from an object that owns a slot returns that slot with status OK. The only state change is that the slot becomes the most recently used.
- R5: A get with cmd_dirty high from an owning object does one of two things. With cmd_tiled high, it keeps the slot and makes it the most recently used. With cmd_tiled low, it releases the slot, or answers BUSY (3) if the slot's pin count is nonzero.
- R6: A put (op 1) releases the object's slot and removes it from the recency order, with status OK. The status is BUSY if the pin count is nonzero, and NOSLOT (4) if the object owns no slot.
- R7: A pin (op 2) raises the owned slot's pin count and answers OK with the slot. It answers NOSLOT if the object owns nothing, and BUSY with no change when the count is already at its maximum.
- R8: An unpin (op 3) lowers the owned slot's pin count with status OK. At a count of zero it answers UNDERFLOW (5) and changes nothing. With no owned slot it answers NOSLOT.
- R9: A get with cmd_tiled low from an object that owns no slot changes no state and answers OK, with rsp_slot 0 and rsp_evict low.
- R10: rsp_valid is high exactly one cycle after a cycle with cmd_valid high. Reset frees every slot and clears all pin counts and response outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 get, 1 put, 2 pin, 3 unpin |
| cmd_id | input | ID_W | Object ID the command refers to |
| cmd_tiled | input | 1 | Object uses a tiled layout (get only) |
| cmd_dirty | input | 1 | Object's tiling parameters changed (get only) |
| release_pending | input | 1 | A pinned slot is expected to be released soon |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | Result code as listed in the requirements |
| rsp_slot | output | SLOT_W | Slot acted on, 0 when none |
| rsp_evict | output | 1 | A slot was taken from another owner |
| rsp_evict_id | output | ID_W | ID of the evicted owner |

## Verification
The hardest case to reach from the ports is a steal whose victim depends on the full recency history. The oldest unpinned slot has to differ from the oldest slot overall, and that order has to have been reshaped by refreshes, dirty re-enables and releases. The vector sequence fills every usable slot, pins chosen slots, refreshes others, and then forces steals whose evicted IDs change if any single recency update is wrong. It also pins all slots to reach the retry and deadlock answers, and a pin counter is driven to saturation.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  typedef enum logic [1:0] {
    OP_GET   = 2'd0,
    OP_PUT   = 2'd1,
    OP_PIN   = 2'd2,
    OP_UNPIN = 2'd3
  } fsa_op_e;

  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_RETRY     = 3'd1,
    ST_DEADLOCK  = 3'd2,
    ST_BUSY      = 3'd3,
    ST_NOSLOT    = 3'd4,
    ST_UNDERFLOW = 3'd5
  } fsa_status_e;
endpackage

// File: rtl/fsa_match.sv
// Owner lookup by ID and lowest free slot search.
module fsa_match #(
  parameter int NUM_SLOTS  = 8,
  parameter int FIRST_SLOT = 0,
  parameter int ID_W       = 8,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0]           own,
  input  logic [NUM_SLOTS-1:0][ID_W-1:0] ids,
  input  logic [ID_W-1:0]                req_id,
  output logic                           hit,
  output logic [SLOT_W-1:0]              hit_idx,
  output logic                           free_found,
  output logic [SLOT_W-1:0]              free_idx
);
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (own[i] && ids[i] == req_id) begin
        hit     = 1'b1;
        hit_idx = SLOT_W'(i);
      end
    end
  end

  // Descending scan so the lowest index wins.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = NUM_SLOTS - 1; i >= FIRST_SLOT; i--) begin
      if (!own[i]) begin
        free_found = 1'b1;
        free_idx   = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/fsa_victim.sv
// Oldest owned slot with no pins.
module fsa_victim #(
  parameter int NUM_SLOTS  = 8,
  parameter int FIRST_SLOT = 0,
  parameter int PIN_W      = 4,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0]             own,
  input  logic [NUM_SLOTS-1:0][PIN_W-1:0]  pins,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0] ages,
  output logic                             found,
  output logic [SLOT_W-1:0]                idx
);
  logic [SLOT_W-1:0] best_age;

  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_age = '0;
    for (int i = FIRST_SLOT; i < NUM_SLOTS; i++) begin
      if (own[i] && pins[i] == '0 && (!found || ages[i] > best_age)) begin
        found    = 1'b1;
        idx      = SLOT_W'(i);
        best_age = ages[i];
      end
    end
  end
endmodule

// File: rtl/fence_slot_alloc.sv
module fence_slot_alloc #(
  parameter int NUM_SLOTS  = 8,
  parameter int FIRST_SLOT = 0,
  parameter int ID_W       = 8,
  parameter int PIN_W      = 4,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic              cmd_tiled,
  input  logic              cmd_dirty,
  input  logic              release_pending,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status,
  output logic [SLOT_W-1:0] rsp_slot,
  output logic              rsp_evict,
  output logic [ID_W-1:0]   rsp_evict_id
);
  import fsa_pkg::*;

  localparam logic [PIN_W-1:0] PIN_MAX = {PIN_W{1'b1}};

  logic [NUM_SLOTS-1:0]             own_q, own_d;
  logic [NUM_SLOTS-1:0][ID_W-1:0]   id_q, id_d;
  logic [NUM_SLOTS-1:0][PIN_W-1:0]  pin_q, pin_d;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0] age_q, age_d;

  logic              rsp_valid_q;
  fsa_status_e       st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              ev_q, ev_d;
  logic [ID_W-1:0]   evid_q, evid_d;

  logic              hit, free_found, vic_found;
  logic [SLOT_W-1:0] hit_idx, free_idx, vic_idx;
  logic              upd, rel;

  fsa_match #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT), .ID_W(ID_W)) u_match (
    .own(own_q), .ids(id_q), .req_id(cmd_id),
    .hit(hit), .hit_idx(hit_idx), .free_found(free_found), .free_idx(free_idx)
  );

  fsa_victim #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT), .PIN_W(PIN_W)) u_victim (
    .own(own_q), .pins(pin_q), .ages(age_q), .found(vic_found), .idx(vic_idx)
  );

  // Command decode
  always_comb begin
    own_d  = own_q;
    id_d   = id_q;
    pin_d  = pin_q;
    st_d   = ST_OK;
    slot_d = '0;
    ev_d   = 1'b0;
    evid_d = '0;
    upd    = 1'b0;
    rel    = 1'b0;
    case (fsa_op_e'(cmd_op))
      OP_GET: begin
        if (hit) begin
          slot_d = hit_idx;
          if (!cmd_dirty || cmd_tiled)  upd  = 1'b1;
          else if (pin_q[hit_idx] != '0) st_d = ST_BUSY;
          else                           rel  = 1'b1;
        end else if (cmd_tiled) begin
          if (free_found) begin
            slot_d          = free_idx;
            upd             = 1'b1;
            own_d[free_idx] = 1'b1;
            id_d[free_idx]  = cmd_id;
          end else if (vic_found) begin
            slot_d         = vic_idx;
            upd            = 1'b1;
            ev_d           = 1'b1;
            evid_d         = id_q[vic_idx];
            id_d[vic_idx]  = cmd_id;
          end else begin
            st_d = release_pending ? ST_RETRY : ST_DEADLOCK;
          end
        end
      end
      OP_PUT: begin
        if (!hit) st_d = ST_NOSLOT;
        else begin
          slot_d = hit_idx;
          if (pin_q[hit_idx] != '0) st_d = ST_BUSY;
          else                      rel  = 1'b1;
        end
      end
      OP_PIN: begin
        if (!hit) st_d = ST_NOSLOT;
        else begin
          slot_d = hit_idx;
          if (pin_q[hit_idx] == PIN_MAX) st_d = ST_BUSY;
          else pin_d[hit_idx] = pin_q[hit_idx] + 1'b1;
        end
      end
      default: begin
        if (!hit) st_d = ST_NOSLOT;
        else begin
          slot_d = hit_idx;
          if (pin_q[hit_idx] == '0) st_d = ST_UNDERFLOW;
          else pin_d[hit_idx] = pin_q[hit_idx] - 1'b1;
        end
      end
    endcase
    if (rel) own_d[slot_d] = 1'b0;
  end

  // Recency update: owned ages stay a permutation of 0..k-1
  always_comb begin
    age_d = age_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (upd) begin
        if (SLOT_W'(i) == slot_d) age_d[i] = '0;
        else if (own_q[i] && (!own_q[slot_d] || age_q[i] < age_q[slot_d]))
          age_d[i] = age_q[i] + 1'b1;
      end else if (rel) begin
        if (SLOT_W'(i) == slot_d) age_d[i] = '0;
        else if (own_q[i] && age_q[i] > age_q[slot_d])
          age_d[i] = age_q[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
      id_q  <= '0;
      pin_q <= '0;
      age_q <= '0;
    end else if (cmd_valid) begin
      own_q <= own_d;
      id_q  <= id_d;
      pin_q <= pin_d;
      age_q <= age_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      st_q        <= ST_OK;
      slot_q      <= '0;
      ev_q        <= 1'b0;
      evid_q      <= '0;
    end else begin
      rsp_valid_q <= cmd_valid;
      if (cmd_valid) begin
        st_q   <= st_d;
        slot_q <= slot_d;
        ev_q   <= ev_d;
        evid_q <= evid_d;
      end
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_status   = st_q;
  assign rsp_slot     = slot_q;
  assign rsp_evict    = ev_q;
  assign rsp_evict_id = evid_q;
endmodule

// File: rtl/fsa_checker.sv
module fsa_checker #(
  parameter int FIRST_SLOT = 0,
  parameter int SLOT_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              release_pending,
  input logic              rsp_valid,
  input logic [2:0]        rsp_status,
  input logic [SLOT_W-1:0] rsp_slot,
  input logic              rsp_evict
);
  import fsa_pkg::*;

  assert_rsp_follows_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  assert_retry_needs_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !release_pending) |=> rsp_status != ST_RETRY);

  assert_deadlock_not_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && release_pending) |=> rsp_status != ST_DEADLOCK);

  assert_evict_ok_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_evict) |-> (rsp_status == ST_OK && int'(rsp_slot) >= FIRST_SLOT));

  assert_evict_only_on_get_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != OP_GET) |=> !rsp_evict);

  assert_pin_no_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PIN) |=>
      (rsp_status == ST_OK || rsp_status == ST_NOSLOT || rsp_status == ST_BUSY));
endmodule

bind fence_slot_alloc fsa_checker #(.FIRST_SLOT(FIRST_SLOT), .SLOT_W(SLOT_W)) u_fsa_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .release_pending(release_pending), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_slot(rsp_slot), .rsp_evict(rsp_evict)
);

// File: tb/test_fence_slot_alloc.sv
module test_fence_slot_alloc;
  localparam int NS = 4;
  localparam int FS = 1;
  localparam int IDW = 8;
  localparam int PW = 2;
  localparam int SW = $clog2(NS);
  localparam int NV = 35;

  logic clk, rst_n, cmd_valid, cmd_tiled, cmd_dirty, release_pending;
  logic [1:0] cmd_op;
  logic [IDW-1:0] cmd_id;
  logic rsp_valid, rsp_evict;
  logic [2:0] rsp_status;
  logic [SW-1:0] rsp_slot;
  logic [IDW-1:0] rsp_evict_id;

  int n_cmp = 0;
  int n_bad = 0;

  fence_slot_alloc #(.NUM_SLOTS(NS), .FIRST_SLOT(FS), .ID_W(IDW), .PIN_W(PW)) i_fence_slot_alloc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
    .cmd_tiled(cmd_tiled), .cmd_dirty(cmd_dirty), .release_pending(release_pending),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_slot(rsp_slot),
    .rsp_evict(rsp_evict), .rsp_evict_id(rsp_evict_id)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {req[30:27], op[26:25], id[24:17], tiled, dirty, pend, status[13:11], slot[10:9], evict, evid[7:0]}
  localparam logic [30:0] VEC [NV] = '{
    {4'd1, 2'd0, 8'h10, 3'b100, 3'd0, 2'd1, 1'b0, 8'h00},  // R1 first usable slot
    {4'd1, 2'd0, 8'h20, 3'b100, 3'd0, 2'd2, 1'b0, 8'h00},  // R1
    {4'd1, 2'd0, 8'h30, 3'b100, 3'd0, 2'd3, 1'b0, 8'h00},  // R1
    {4'd4, 2'd0, 8'h10, 3'b100, 3'd0, 2'd1, 1'b0, 8'h00},  // R4 refresh
    {4'd2, 2'd0, 8'h40, 3'b100, 3'd0, 2'd2, 1'b1, 8'h20},  // R2 steal oldest
    {4'd7, 2'd2, 8'h30, 3'b000, 3'd0, 2'd3, 1'b0, 8'h00},  // R7 pin
    {4'd2, 2'd0, 8'h50, 3'b100, 3'd0, 2'd1, 1'b1, 8'h10},  // R2 skips pinned
    {4'd6, 2'd1, 8'h30, 3'b000, 3'd3, 2'd3, 1'b0, 8'h00},  // R6 busy
    {4'd8, 2'd3, 8'h30, 3'b000, 3'd0, 2'd3, 1'b0, 8'h00},  // R8 unpin
    {4'd8, 2'd3, 8'h30, 3'b000, 3'd5, 2'd3, 1'b0, 8'h00},  // R8 underflow
    {4'd7, 2'd2, 8'h99, 3'b000, 3'd4, 2'd0, 1'b0, 8'h00},  // R7 no slot
    {4'd9, 2'd0, 8'h60, 3'b000, 3'd0, 2'd0, 1'b0, 8'h00},  // R9 untiled no-op
    {4'd6, 2'd1, 8'h30, 3'b000, 3'd0, 2'd3, 1'b0, 8'h00},  // R6 release (proves R9 kept id30)
    {4'd1, 2'd0, 8'h70, 3'b100, 3'd0, 2'd3, 1'b0, 8'h00},  // R1 reuse freed slot
    {4'd7, 2'd2, 8'h70, 3'b000, 3'd0, 2'd3, 1'b0, 8'h00},  // R7
    {4'd7, 2'd2, 8'h40, 3'b000, 3'd0, 2'd2, 1'b0, 8'h00},  // R7
    {4'd7, 2'd2, 8'h50, 3'b000, 3'd0, 2'd1, 1'b0, 8'h00},  // R7
    {4'd3, 2'd0, 8'h80, 3'b100, 3'd2, 2'd0, 1'b0, 8'h00},  // R3 deadlock
    {4'd3, 2'd0, 8'h80, 3'b101, 3'd1, 2'd0, 1'b0, 8'h00},  // R3 retry
    {4'd5, 2'd0, 8'h50, 3'b110, 3'd0, 2'd1, 1'b0, 8'h00},  // R5 re-enable
    {4'd8, 2'd3, 8'h40, 3'b000, 3'd0, 2'd2, 1'b0, 8'h00},  // R8
    {4'd8, 2'd3, 8'h70, 3'b000, 3'd0, 2'd3, 1'b0, 8'h00},  // R8
    {4'd2, 2'd0, 8'h81, 3'b100, 3'd0, 2'd2, 1'b1, 8'h40},  // R2
    {4'd5, 2'd0, 8'h70, 3'b110, 3'd0, 2'd3, 1'b0, 8'h00},  // R5 re-enable to MRU
    {4'd8, 2'd3, 8'h50, 3'b000, 3'd0, 2'd1, 1'b0, 8'h00},  // R8
    {4'd5, 2'd0, 8'h84, 3'b100, 3'd0, 2'd1, 1'b1, 8'h50},  // R5 victim shows re-enable order
    {4'd5, 2'd0, 8'h70, 3'b010, 3'd0, 2'd3, 1'b0, 8'h00},  // R5 dirty untiled releases
    {4'd1, 2'd0, 8'h85, 3'b100, 3'd0, 2'd3, 1'b0, 8'h00},  // R1
    {4'd2, 2'd0, 8'h86, 3'b100, 3'd0, 2'd2, 1'b1, 8'h81},  // R2 order after release
    {4'd7, 2'd2, 8'h86, 3'b000, 3'd0, 2'd2, 1'b0, 8'h00},  // R7
    {4'd7, 2'd2, 8'h86, 3'b000, 3'd0, 2'd2, 1'b0, 8'h00},  // R7
    {4'd7, 2'd2, 8'h86, 3'b000, 3'd0, 2'd2, 1'b0, 8'h00},  // R7
    {4'd7, 2'd2, 8'h86, 3'b000, 3'd3, 2'd2, 1'b0, 8'h00},  // R7 saturated
    {4'd5, 2'd0, 8'h86, 3'b010, 3'd3, 2'd2, 1'b0, 8'h00},  // R5 pinned release busy
    {4'd8, 2'd3, 8'h86, 3'b000, 3'd0, 2'd2, 1'b0, 8'h00}   // R8
  };

  task automatic check(input int req, input logic [2:0] st, input logic [SW-1:0] sl,
                       input logic ev, input logic [IDW-1:0] evid);
    n_cmp++;
    if (rsp_valid !== 1'b1 || rsp_status !== st || rsp_slot !== sl ||
        rsp_evict !== ev || (ev && rsp_evict_id !== evid)) begin
      n_bad++;
      $display("FAIL R%0d: got v=%0b st=%0d slot=%0d ev=%0b id=%h, expected v=1 st=%0d slot=%0d ev=%0b id=%h",
               req, rsp_valid, rsp_status, rsp_slot, rsp_evict, rsp_evict_id, st, sl, ev, evid);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the response.
  task automatic issue(input logic [1:0] op, input logic [IDW-1:0] id,
                       input logic t, input logic d, input logic p);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id;
    cmd_tiled = t; cmd_dirty = d; release_pending = p;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_id = '0;
    cmd_tiled = 1'b0; cmd_dirty = 1'b0; release_pending = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    n_cmp++;
    if (rsp_valid !== 1'b0 || rsp_status !== 3'd0 || rsp_evict !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: after reset v=%0b st=%0d ev=%0b, expected 0 0 0",
               rsp_valid, rsp_status, rsp_evict);
    end
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][26:25], VEC[k][24:17], VEC[k][16], VEC[k][15], VEC[k][14]);
      check(int'(VEC[k][30:27]), VEC[k][13:11], VEC[k][10:9], VEC[k][8], VEC[k][7:0]);
    end

    // R10 idle cycle gives no response
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: idle rsp_valid=%0b, expected 0", rsp_valid);
    end

    // R10 reset mid-run frees all slots: next get takes slot FS without eviction
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(2'd0, 8'h90, 1'b1, 1'b0, 1'b0);
    check(10, 3'd0, SW'(FS), 1'b0, 8'h00);
    // R10 pin count cleared by reset: unpin underflows
    issue(2'd3, 8'h90, 1'b0, 1'b0, 1'b0);
    check(10, 3'd5, SW'(FS), 1'b0, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R10: watchdog expired, got hang, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule